// File: doc/BRIEF.md
# Interrupt Enable, Pending and Active State Bank

This block holds three state bits per interrupt (enable, pending, active) and one trigger-type bit per interrupt. Software changes the bits through word registers that come in pairs: one alias sets every bit written as 1, the other clears every bit written as 1. The trigger types are reached through a separate configuration register that packs two bit positions per interrupt. A permission mask from outside the block gates each bit of every read and write, so a neighbouring security or ownership unit can hide interrupts from the requester.

Interrupt input lines enter the block directly. A rising line latches the pending bit only for an interrupt configured as edge-triggered. For a level-triggered interrupt the pending value that software reads is the latch ORed with the present line level. Interrupts are grouped into banks of 32. Bank 0 (interrupts 0 to 31) is not implemented here, and neither are banks at or above the implemented count. Each implemented bank raises a one-cycle update strobe whenever its stored state changes, so a downstream arbiter can rescan only that bank.

Top module: `irq_state_bank`

## Requirements
- R1: A write to a set alias (enable region 0, pending region 2, active region 4) sets every state bit whose write-data bit is 1 and leaves every other bit unchanged.
- R2: A write to a clear alias (enable region 1, pending region 3, active region 5) clears every state bit whose write-data bit is 1 and leaves every other bit unchanged. Both aliases of one state read back the same stored word.
- R3: Bitmap word index w covers interrupts 32w to 32w+31. Word 0, and any word with w at or above NUM_IRQ/32, reads as zero and ignores writes.
- R4: A pending read returns, bit by bit, the pending latch OR (line level AND NOT edge-triggered).
- R5: A 0-to-1 change on an input line sets the pending latch only when that interrupt is edge-triggered. A line that holds its level sets nothing. A level-triggered line never sets the latch. When an edge and a pending-clear write of the same bit arrive in the same cycle, the bit ends up set.
- R6: Write data and read data are both ANDed bit by bit with perm_mask. A masked-off bit keeps its stored value on a write and reads as 0.
- R7: Configuration word k (region 6) covers interrupts 16k to 16k+15. The edge setting of interrupt 16k+j sits in bit 2j+1, and even bits read as 0. A write changes only those 16 interrupts, each gated by the perm_mask bit of the interrupt's position within its 32-interrupt bank (bit 16*(k mod 2)+j).
- R8: rd_data presents, on the cycle after the address is applied, the value for that address. After reset all state bits are 0 (every interrupt level-triggered), rd_data is 0 and no strobe is high.
- R9: upd_strobe[b] is high for exactly one cycle after a clock edge at which a write or a line-level change altered bank b's enable, pending, active, trigger or sampled-level state. A write that leaves all state as it was raises no strobe.
- R10: addr[IDX_W+2:IDX_W] selects the region and addr[IDX_W-1:0] selects the word. Region 7 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | IDX_W+3 | Region and word select |
| wr_data | input | 32 | Write data |
| perm_mask | input | 32 | Per-bit access permission for the current access |
| irq_lines | input | NUM_IRQ | Interrupt input lines (lines 0 to 31 unused) |
| rd_data | output | 32 | Registered read data |
| upd_strobe | output | NUM_IRQ/32 | Per-bank state-change pulse |

## Verification
A corrupted enable or active bit shows up on the next read of either alias, one cycle after the address is applied. A wrong pending latch or trigger bit may stay hidden while the line is low. It only appears once a line toggles: either a level-triggered interrupt fails to follow its line in the pending read, or an edge-triggered one fails to keep its latched bit after the line falls. A wrong bank selection shows up the same cycle as a strobe on the wrong bank, or as a strobe after a write that should have changed nothing.

// File: rtl/irq_bank_pkg.sv
// Shared types and helpers for the interrupt state bank.
// Assumes 32 interrupts per bank and a 3-bit region field.
package irq_bank_pkg;

    typedef enum logic [2:0] {
        RG_EN_SET = 3'd0,
        RG_EN_CLR = 3'd1,
        RG_PD_SET = 3'd2,
        RG_PD_CLR = 3'd3,
        RG_AC_SET = 3'd4,
        RG_AC_CLR = 3'd5,
        RG_CFG    = 3'd6,
        RG_NONE   = 3'd7
    } region_e;

    // Gather the odd bit positions of a configuration word into 16 bits.
    function automatic logic [15:0] pack_odd(input logic [31:0] w);
        logic [15:0] r;
        for (int j = 0; j < 16; j++) r[j] = w[2*j+1];
        return r;
    endfunction

    // Spread 16 edge bits into the odd positions of a word, even bits zero.
    function automatic logic [31:0] spread_odd(input logic [15:0] h);
        logic [31:0] r;
        r = '0;
        for (int j = 0; j < 16; j++) r[2*j+1] = h[j];
        return r;
    endfunction

endpackage

// File: rtl/irq_bank_decode.sv
// Address decoder: splits an address into region, bank and half.
// Bitmap words map one-to-one to banks; configuration words map two per bank.
// Assumes bank 0 is never implemented.
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int NBANK = 3
) (
    input  logic [IDX_W+2:0] addr,
    output region_e          region,
    output logic [IDX_W-1:0] bank,
    output logic             half,
    output logic             bank_ok
);
    localparam int ADDR_W = IDX_W + 3;

    logic [IDX_W-1:0] idx;

    // Split the address into fields and check that the target bank exists.
    always_comb begin
        region = region_e'(addr[ADDR_W-1 -: 3]);
        idx    = addr[IDX_W-1:0];
        if (region == RG_CFG) begin
            bank = {1'b0, idx[IDX_W-1:1]};
            half = idx[0];
        end else begin
            bank = idx;
            half = 1'b0;
        end
        bank_ok = (region != RG_NONE) && (bank != '0) && (int'(bank) < NBANK);
    end

endmodule

// File: rtl/irq_bank_slice.sv
// State for one bank of 32 interrupts: enable, pending latch, active,
// edge configuration and sampled line level. Applies set/clear writes under
// the permission mask, latches pending on rising edges of edge-triggered
// lines, and pulses upd_o one cycle after any stored change.
// Assumes wr_hit is already qualified with the bank select.
module irq_bank_slice
    import irq_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  region_e     region,
    input  logic        half,
    input  logic [31:0] wdata,
    input  logic [31:0] perm,
    input  logic [31:0] lines,
    output logic [31:0] en_o,
    output logic [31:0] pend_o,
    output logic [31:0] act_o,
    output logic [31:0] edge_o,
    output logic        upd_o
);
    logic [31:0] en_q, pend_q, act_q, edge_q, line_q;
    logic [31:0] en_n, pend_n, act_n, edge_n;
    logic [31:0] wm, rise, cfg_m, cfg_v;
    logic [15:0] mask_h, val_h;

    // Next-state computation for every stored bit of the bank.
    always_comb begin
        wm     = wdata & perm;
        rise   = lines & ~line_q;
        mask_h = half ? perm[31:16] : perm[15:0];
        val_h  = pack_odd(wdata);
        cfg_m  = half ? {mask_h, 16'h0} : {16'h0, mask_h};
        cfg_v  = half ? {val_h, 16'h0}  : {16'h0, val_h};
        en_n   = en_q;
        act_n  = act_q;
        edge_n = edge_q;
        pend_n = pend_q;
        if (wr_hit) begin
            case (region)
                RG_EN_SET: en_n   = en_q | wm;
                RG_EN_CLR: en_n   = en_q & ~wm;
                RG_PD_SET: pend_n = pend_q | wm;
                RG_PD_CLR: pend_n = pend_q & ~wm;
                RG_AC_SET: act_n  = act_q | wm;
                RG_AC_CLR: act_n  = act_q & ~wm;
                RG_CFG:    edge_n = (edge_q & ~cfg_m) | (cfg_v & cfg_m);
                default:   ;
            endcase
        end
        pend_n = pend_n | (rise & edge_q);
    end

    // State registers and the change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            edge_q <= '0;
            line_q <= '0;
            upd_o  <= 1'b0;
        end else begin
            en_q   <= en_n;
            pend_q <= pend_n;
            act_q  <= act_n;
            edge_q <= edge_n;
            line_q <= lines;
            upd_o  <= (en_n != en_q) || (pend_n != pend_q) || (act_n != act_q) ||
                      (edge_n != edge_q) || (lines != line_q);
        end
    end

    assign en_o   = en_q;
    assign act_o  = act_q;
    assign edge_o = edge_q;
    assign pend_o = pend_q | (line_q & ~edge_q);

endmodule

// File: rtl/irq_state_bank.sv
// Top of the interrupt state bank. Decodes the register address, holds one
// slice per implemented bank (bank 0 reads as zero), and registers the read
// value one cycle after the address. Assumes NUM_IRQ is a multiple of 32
// and at most 32 * 2**(IDX_W-1) so every configuration word is addressable.
module irq_state_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int IDX_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W+2:0]      addr,
    input  logic [31:0]           wr_data,
    input  logic [31:0]           perm_mask,
    input  logic [NUM_IRQ-1:0]    irq_lines,
    output logic [31:0]           rd_data,
    output logic [NUM_IRQ/32-1:0] upd_strobe
);
    localparam int NBANK = NUM_IRQ / 32;

    region_e          region;
    logic [IDX_W-1:0] bank;
    logic             half, bank_ok;
    logic [31:0]      en_v   [NBANK];
    logic [31:0]      pend_v [NBANK];
    logic [31:0]      act_v  [NBANK];
    logic [31:0]      edge_v [NBANK];
    logic [31:0]      rd_next, em;

    irq_bank_decode #(.IDX_W(IDX_W), .NBANK(NBANK)) u_dec (
        .addr    (addr),
        .region  (region),
        .bank    (bank),
        .half    (half),
        .bank_ok (bank_ok)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        if (b == 0) begin : g_absent
            assign en_v[b]       = '0;
            assign pend_v[b]     = '0;
            assign act_v[b]      = '0;
            assign edge_v[b]     = '0;
            assign upd_strobe[b] = 1'b0;
        end else begin : g_slice
            irq_bank_slice u_slice (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (wr_en && bank_ok && (int'(bank) == b)),
                .region (region),
                .half   (half),
                .wdata  (wr_data),
                .perm   (perm_mask),
                .lines  (irq_lines[32*b +: 32]),
                .en_o   (en_v[b]),
                .pend_o (pend_v[b]),
                .act_o  (act_v[b]),
                .edge_o (edge_v[b]),
                .upd_o  (upd_strobe[b])
            );
        end
    end

    // Select the masked read value for the addressed word.
    always_comb begin
        rd_next = '0;
        em      = '0;
        for (int b = 1; b < NBANK; b++) begin
            if (bank_ok && int'(bank) == b) begin
                case (region)
                    RG_EN_SET, RG_EN_CLR: rd_next = en_v[b] & perm_mask;
                    RG_PD_SET, RG_PD_CLR: rd_next = pend_v[b] & perm_mask;
                    RG_AC_SET, RG_AC_CLR: rd_next = act_v[b] & perm_mask;
                    RG_CFG: begin
                        em      = edge_v[b] & perm_mask;
                        rd_next = spread_odd(half ? em[31:16] : em[15:0]);
                    end
                    default: rd_next = '0;
                endcase
            end
        end
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

endmodule

// File: rtl/irq_state_bank_chk.sv
// Port-level property checker for irq_state_bank, bound to every instance.
// Assumes the address layout of the top: region in the three upper bits.
module irq_state_bank_chk #(
    parameter int NUM_IRQ = 96,
    parameter int IDX_W   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [IDX_W+2:0]      addr,
    input logic [31:0]           perm_mask,
    input logic [NUM_IRQ-1:0]    irq_lines,
    input logic [31:0]           rd_data,
    input logic [NUM_IRQ/32-1:0] upd_strobe
);
    localparam int ADDR_W = IDX_W + 3;

    logic live, live2;
    logic [2:0] rg;

    assign rg = addr[ADDR_W-1 -: 3];

    // Track how many edges have passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live  <= 1'b0;
            live2 <= 1'b0;
        end else begin
            live  <= 1'b1;
            live2 <= live;
        end
    end

    // R3: bitmap word 0 always reads as zero
    p_raz_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(rg) < 3'd6 && $past(addr[IDX_W-1:0]) == '0 |-> rd_data == '0);

    // R6: no read bit outside the permission mask of the access
    p_mask_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(rg) < 3'd6 |-> (rd_data & ~$past(perm_mask)) == '0);

    // R7: configuration reads carry no even bits
    p_cfg_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(rg) == 3'd6 |-> (rd_data & 32'h5555_5555) == '0);

    // R10: region 7 reads as zero
    p_none_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(rg) == 3'd7 |-> rd_data == '0);

    // R9: no write and steady lines give no strobe
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        live && live2 && !$past(wr_en) && $past(irq_lines) == $past(irq_lines, 2)
        |-> upd_strobe == '0);

endmodule

bind irq_state_bank irq_state_bank_chk #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .perm_mask  (perm_mask),
    .irq_lines  (irq_lines),
    .rd_data    (rd_data),
    .upd_strobe (upd_strobe)
);

// File: tb/irq_state_bank_tb.sv
module irq_state_bank_tb;
    localparam int NUM_IRQ = 96;
    localparam int IDX_W   = 4;
    localparam int NBANK   = NUM_IRQ / 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [IDX_W+2:0]     addr = '0;
    logic [31:0]          wr_data = '0;
    logic [31:0]          perm_mask = '1;
    logic [NUM_IRQ-1:0]   irq_lines = '0;
    logic [31:0]          rd_data;
    logic [NBANK-1:0]     upd_strobe;
    logic [NBANK-1:0]     last_upd;
    int                   n_chk = 0;
    int                   n_bad = 0;
    bit                   done = 1'b0;

    always #5 clk = ~clk;

    irq_state_bank #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .perm_mask(perm_mask), .irq_lines(irq_lines), .rd_data(rd_data),
        .upd_strobe(upd_strobe)
    );

    // Address codes: {region[2:0], word[3:0]}
    typedef struct packed {
        logic [6:0]  wa;
        logic [31:0] wd;
        logic [31:0] wp;
        logic [6:0]  ra;
        logic [31:0] rp;
        logic [31:0] ex;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VECS [17] = '{
        '{7'h01, 32'h0000_00F0, 32'hFFFF_FFFF, 7'h01, 32'hFFFF_FFFF, 32'h0000_00F0, 4'd1},  // R1
        '{7'h01, 32'h0000_0F00, 32'hFFFF_FFFF, 7'h11, 32'hFFFF_FFFF, 32'h0000_0FF0, 4'd1},  // R1
        '{7'h11, 32'h0000_0030, 32'hFFFF_FFFF, 7'h01, 32'hFFFF_FFFF, 32'h0000_0FC0, 4'd2},  // R2
        '{7'h01, 32'hFFFF_0000, 32'h00FF_0000, 7'h01, 32'hFFFF_FFFF, 32'h00FF_0FC0, 4'd6},  // R6
        '{7'h11, 32'hFFFF_FFFF, 32'h0000_0F00, 7'h01, 32'hFFFF_FFFF, 32'h00FF_00C0, 4'd6},  // R6
        '{7'h70, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 7'h01, 32'h0000_00FF, 32'h0000_00C0, 4'd6},  // R6
        '{7'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 7'h00, 32'hFFFF_FFFF, 32'h0000_0000, 4'd3},  // R3
        '{7'h03, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 7'h03, 32'hFFFF_FFFF, 32'h0000_0000, 4'd3},  // R3
        '{7'h42, 32'h8000_0001, 32'hFFFF_FFFF, 7'h52, 32'hFFFF_FFFF, 32'h8000_0001, 4'd1},  // R1
        '{7'h52, 32'h0000_0001, 32'hFFFF_FFFF, 7'h42, 32'hFFFF_FFFF, 32'h8000_0000, 4'd2},  // R2
        '{7'h62, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 7'h62, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 4'd7},  // R7
        '{7'h70, 32'h0000_0000, 32'hFFFF_FFFF, 7'h63, 32'hFFFF_FFFF, 32'h0000_0000, 4'd7},  // R7
        '{7'h63, 32'hFFFF_FFFF, 32'h0003_0000, 7'h63, 32'hFFFF_FFFF, 32'h0000_000A, 4'd7},  // R7
        '{7'h70, 32'h0000_0000, 32'hFFFF_FFFF, 7'h62, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 4'd7},  // R7
        '{7'h62, 32'h0000_0002, 32'hFFFF_FFFF, 7'h62, 32'hFFFF_FFFF, 32'h0000_0002, 4'd7},  // R7
        '{7'h21, 32'h0000_0100, 32'hFFFF_FFFF, 7'h21, 32'hFFFF_FFFF, 32'h0000_0100, 4'd1},  // R1
        '{7'h31, 32'h0000_0100, 32'hFFFF_FFFF, 7'h21, 32'hFFFF_FFFF, 32'h0000_0000, 4'd2}   // R2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [31:0] d, input logic [31:0] p);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d; perm_mask = p;
        @(negedge clk);
        wr_en = 1'b0;
        last_upd = upd_strobe;
    endtask

    task automatic do_read(input logic [6:0] a, input logic [31:0] p,
                           input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 1'b0; addr = a; perm_mask = p;
        @(negedge clk);
        check(tag, rd_data, exp);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        check("R8 strobe after reset", 32'(upd_strobe), 32'h0);
        do_read(7'h01, '1, 32'h0, "R8 enable reset");
        do_read(7'h21, '1, 32'h0, "R8 pending reset");
        do_read(7'h62, '1, 32'h0, "R8 config reset");

        // Table walk
        for (int i = 0; i < 17; i++) begin
            do_write(VECS[i].wa, VECS[i].wd, VECS[i].wp);
            do_read(VECS[i].ra, VECS[i].rp, VECS[i].ex, $sformatf("R%0d vector %0d", VECS[i].rq, i));
        end

        // R10: unmapped region
        do_read(7'h71, '1, 32'h0, "R10 region 7 read");

        // R4: level-triggered interrupt 37 follows its line; R9 strobe on line change
        @(negedge clk); irq_lines[37] = 1'b1;
        @(negedge clk);
        check("R9 strobe on line rise", 32'(upd_strobe), 32'h2);
        do_read(7'h21, '1, 32'h0000_0020, "R4 level merge");
        do_read(7'h21, 32'h0000_000F, 32'h0, "R6 pending read masked");
        @(negedge clk); irq_lines[37] = 1'b0;
        do_read(7'h21, '1, 32'h0, "R5 level line not latched");

        // R5: edge interrupt 32 latches
        @(negedge clk); irq_lines[32] = 1'b1;
        @(negedge clk); irq_lines[32] = 1'b0;
        do_read(7'h21, '1, 32'h0000_0001, "R5 edge latched");
        do_write(7'h31, 32'h1, '1);
        do_read(7'h21, '1, 32'h0, "R2 edge latch cleared");

        // R5: steady high level does not re-latch
        @(negedge clk); irq_lines[32] = 1'b1;
        @(negedge clk);
        do_write(7'h31, 32'h1, '1);
        repeat (3) @(negedge clk);
        do_read(7'h21, '1, 32'h0, "R5 held level ignored");
        @(negedge clk); irq_lines[32] = 1'b0;

        // R5: edge and clear in the same cycle, set wins
        @(negedge clk);
        irq_lines[48] = 1'b1;
        wr_en = 1'b1; addr = 7'h31; wr_data = 32'h0001_0000; perm_mask = '1;
        @(negedge clk); wr_en = 1'b0;
        do_read(7'h21, '1, 32'h0001_0000, "R5 edge beats clear");
        do_write(7'h31, 32'h0001_0000, '1);
        do_read(7'h21, '1, 32'h0, "R2 clear after edge");
        @(negedge clk); irq_lines[48] = 1'b0;
        repeat (2) @(negedge clk);

        // R9: strobe per bank and only on change
        do_write(7'h02, 32'h0000_0008, '1);
        check("R9 strobe bank 2", 32'(last_upd), 32'h4);
        do_write(7'h02, 32'h0000_0008, '1);
        check("R9 no strobe on repeat", 32'(last_upd), 32'h0);
        do_write(7'h02, 32'h0000_0000, '1);
        check("R9 no strobe on zero data", 32'(last_upd), 32'h0);
        do_write(7'h00, 32'hFFFF_FFFF, '1);
        check("R3 no strobe for bank 0", 32'(last_upd), 32'h0);
        do_read(7'h02, '1, 32'h0000_0008, "R1 bank 2 enable");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule